// File: doc/BRIEF.md
# Trapezoidal Fixed-Point Integrator

This block integrates a stream of signed error samples with the trapezoidal rule. Each accepted sample is added to the sample accepted before it. The pair sum is multiplied by a gain coefficient and halved with an arithmetic right shift. The result is then added to a running total held in an accumulator register. The lowest bit dropped by the halving shift is lost, so the integrated value is quantized toward negative infinity.

A sample is taken only on an active clock edge when the sample-valid strobe is high. A build parameter selects whether the rising or the falling clock edge is active. A second parameter selects whether the data ports are read as signed or unsigned. When the total leaves its range, it clamps at the nearest limit and does not wrap. A synchronous reset clears both the stored previous sample and the total.

Top module: `trap_integrator`

## Requirements
- R1: When `rst` is high on an active edge, `accOut` and the stored previous sample both become zero, whatever `sampleValid` is.
- R2: On an active edge with `sampleValid` high and `rst` low, `accOut` becomes `accOut + ((errIn + prev) * gainIn) >>> 1`. Here `prev` is the stored previous sample, and all values are two's complement in signed mode.
- R3: Every accepted sample is stored as `prev` for the next accepted sample. The first sample after reset pairs with zero.
- R4: On an active edge with `sampleValid` low, `accOut` and the stored previous sample keep their values. Any `errIn` or `gainIn` present on that edge has no effect.
- R5: If the new total would be greater than the largest value `accOut` can hold (2^(ACC_W-1)-1 in signed mode, 8388607 with the defaults), `accOut` becomes that largest value.
- R6: If the new total would be less than the smallest value `accOut` can hold (-2^(ACC_W-1) in signed mode, -8388608 with the defaults), `accOut` becomes that smallest value.
- R7: `accOut` changes only on the active edge, which is the rising edge when `RISING_EDGE` is 1. An accepted sample shows on `accOut` right after that edge, one register after the inputs.
- R8: The halving shift floors the product. For example, a pair sum of -3 with a gain of 1 adds -2, and a pair sum of 3 adds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the active edge is set by `RISING_EDGE` |
| rst | input | 1 | Synchronous reset, active high |
| sampleValid | input | 1 | A sample is accepted on this edge |
| errIn | input | DATA_W | Error sample |
| gainIn | input | GAIN_W | Gain coefficient |
| accOut | output | ACC_W | Integrated total |

## Verification
Reset and sample acceptance can fall on the same edge. The bench provokes this by holding `sampleValid` high with a nonzero error on the reset edge. It then judges two things: `accOut` must read zero, and a following zero-error sample must leave the total at zero, which shows that the stored previous sample was cleared and not loaded. Saturation can also coincide with a sign reversal of the added term. The bench drives the total into the positive limit and then turns the gain negative, so the total must move away from that limit and clamp at the negative limit.

// File: rtl/trap_integ_pkg.sv
package trap_integ_pkg;

  // Strobes from the control to the datapath for one active edge
  typedef struct packed {
    logic clearRegs;  // zero the previous sample and the total
    logic loadPrev;   // capture the current error as previous sample
    logic loadAcc;    // write the new total
  } integ_ctrl_t;

endpackage

// File: rtl/trap_integ_edge.sv
module trap_integ_edge #(
  parameter bit RISING_EDGE = 1'b1
) (
  input  logic clk,
  output logic sampleClk
);

  generate
    if (RISING_EDGE) begin : g_rise
      assign sampleClk = clk;
    end else begin : g_fall
      assign sampleClk = ~clk;
    end
  endgenerate

endmodule

// File: rtl/trap_integ_ctrl.sv
module trap_integ_ctrl
  import trap_integ_pkg::*;
(
  input  logic        rst,
  input  logic        sampleValid,
  output integ_ctrl_t ctrl
);

  // Reset takes priority over acceptance of a sample
  always_comb begin
    ctrl           = '0;
    ctrl.clearRegs = rst;
    if (!rst && sampleValid) begin
      ctrl.loadPrev = 1'b1;
      ctrl.loadAcc  = 1'b1;
    end
  end

endmodule

// File: rtl/trap_integ_dp.sv
module trap_integ_dp
  import trap_integ_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int GAIN_W      = 8,
  parameter int ACC_W       = 24,
  parameter bit SIGNED_DATA = 1'b1
) (
  input  logic              sampleClk,
  input  integ_ctrl_t       ctrl,
  input  logic [DATA_W-1:0] errIn,
  input  logic [GAIN_W-1:0] gainIn,
  output logic [ACC_W-1:0]  accOut
);

  localparam int SUM_W  = DATA_W + 2;
  localparam int GX_W   = GAIN_W + 1;
  localparam int PROD_W = SUM_W + GX_W;
  localparam int BASE_W = (PROD_W > ACC_W + 1) ? PROD_W : ACC_W + 1;
  localparam int WIDE_W = BASE_W + 1;
  localparam longint MAX_L = SIGNED_DATA ? (64'sd1 <<< (ACC_W - 1)) - 1
                                         : (64'sd1 <<< ACC_W) - 1;
  localparam longint MIN_L = SIGNED_DATA ? -(64'sd1 <<< (ACC_W - 1)) : 64'sd0;
  localparam logic signed [WIDE_W-1:0] MAX_V = WIDE_W'(MAX_L);
  localparam logic signed [WIDE_W-1:0] MIN_V = WIDE_W'(MIN_L);

  logic [DATA_W-1:0]        prevReg;
  logic [ACC_W-1:0]         accReg;
  logic signed [DATA_W:0]   errExt;
  logic signed [DATA_W:0]   prevExt;
  logic signed [GAIN_W:0]   gainExt;
  logic signed [SUM_W-1:0]  pairSum;
  logic signed [PROD_W-1:0] prodVal;
  logic signed [PROD_W-1:0] halfVal;
  logic signed [WIDE_W-1:0] accExt;
  logic signed [WIDE_W-1:0] nextWide;
  logic [ACC_W-1:0]         accNext;

  // Widen operands by one bit: sign copy or zero, per interpretation
  always_comb begin
    errExt  = signed'({(SIGNED_DATA ? errIn[DATA_W-1]   : 1'b0), errIn});
    prevExt = signed'({(SIGNED_DATA ? prevReg[DATA_W-1] : 1'b0), prevReg});
    gainExt = signed'({(SIGNED_DATA ? gainIn[GAIN_W-1]  : 1'b0), gainIn});
    accExt  = WIDE_W'(signed'({(SIGNED_DATA ? accReg[ACC_W-1] : 1'b0), accReg}));
  end

  // Trapezoid term: (e[n] + e[n-1]) * k, halved with floor
  always_comb begin
    pairSum  = SUM_W'(errExt) + SUM_W'(prevExt);
    prodVal  = PROD_W'(pairSum) * PROD_W'(gainExt);
    halfVal  = prodVal >>> 1;
    nextWide = accExt + WIDE_W'(halfVal);
  end

  // Clamp to the output range
  always_comb begin
    if (nextWide > MAX_V) begin
      accNext = MAX_V[ACC_W-1:0];
    end else if (nextWide < MIN_V) begin
      accNext = MIN_V[ACC_W-1:0];
    end else begin
      accNext = nextWide[ACC_W-1:0];
    end
  end

  always_ff @(posedge sampleClk) begin
    if (ctrl.clearRegs) begin
      prevReg <= '0;
      accReg  <= '0;
    end else begin
      if (ctrl.loadPrev) prevReg <= errIn;
      if (ctrl.loadAcc)  accReg  <= accNext;
    end
  end

  assign accOut = accReg;

endmodule

// File: rtl/trap_integrator.sv
module trap_integrator
  import trap_integ_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int GAIN_W      = 8,
  parameter int ACC_W       = 24,
  parameter bit SIGNED_DATA = 1'b1,
  parameter bit RISING_EDGE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] errIn,
  input  logic [GAIN_W-1:0] gainIn,
  output logic [ACC_W-1:0]  accOut
);

  logic        sampleClk;
  integ_ctrl_t ctrl;

  trap_integ_edge #(.RISING_EDGE(RISING_EDGE)) u_edge (
    .clk       (clk),
    .sampleClk (sampleClk)
  );

  trap_integ_ctrl u_ctrl (
    .rst         (rst),
    .sampleValid (sampleValid),
    .ctrl        (ctrl)
  );

  trap_integ_dp #(
    .DATA_W      (DATA_W),
    .GAIN_W      (GAIN_W),
    .ACC_W       (ACC_W),
    .SIGNED_DATA (SIGNED_DATA)
  ) u_dp (
    .sampleClk (sampleClk),
    .ctrl      (ctrl),
    .errIn     (errIn),
    .gainIn    (gainIn),
    .accOut    (accOut)
  );

endmodule

// File: rtl/trap_integrator_chk.sv
module trap_integrator_chk #(
  parameter int DATA_W      = 12,
  parameter int GAIN_W      = 8,
  parameter int ACC_W       = 24,
  parameter bit SIGNED_DATA = 1'b1
) (
  input logic              sampleClk,
  input logic              rst,
  input logic              sampleValid,
  input logic [DATA_W-1:0] errIn,
  input logic [GAIN_W-1:0] gainIn,
  input logic [ACC_W-1:0]  accOut
);

  localparam longint MAX_L = SIGNED_DATA ? (64'sd1 <<< (ACC_W - 1)) - 1
                                         : (64'sd1 <<< ACC_W) - 1;
  localparam longint MIN_L = SIGNED_DATA ? -(64'sd1 <<< (ACC_W - 1)) : 64'sd0;
  localparam logic [ACC_W-1:0] MAX_P = ACC_W'(MAX_L);
  localparam logic [ACC_W-1:0] MIN_P = ACC_W'(MIN_L);

  // Last accepted sample, tracked from the ports
  logic [DATA_W-1:0]      lastErr;
  logic signed [DATA_W+1:0] obsSum;
  logic signed [GAIN_W:0]   obsGain;

  always_ff @(posedge sampleClk) begin
    if (rst) lastErr <= '0;
    else if (sampleValid) lastErr <= errIn;
  end

  always_comb begin
    obsSum  = (DATA_W+2)'(signed'({(SIGNED_DATA ? errIn[DATA_W-1]   : 1'b0), errIn}))
            + (DATA_W+2)'(signed'({(SIGNED_DATA ? lastErr[DATA_W-1] : 1'b0), lastErr}));
    obsGain = signed'({(SIGNED_DATA ? gainIn[GAIN_W-1] : 1'b0), gainIn});
  end

  AST_RESET_CLEARS: assert property (@(posedge sampleClk)
    rst |=> accOut == '0);  // R1

  AST_ZERO_PAIR_HOLDS: assert property (@(posedge sampleClk) disable iff (rst)
    (sampleValid && obsSum == 0) |=> $stable(accOut));  // R2

  AST_IDLE_HOLDS: assert property (@(posedge sampleClk) disable iff (rst)
    !sampleValid |=> $stable(accOut));  // R4

  AST_CLAMP_HIGH: assert property (@(posedge sampleClk) disable iff (rst)
    (sampleValid && accOut == MAX_P && obsSum >= 0 && obsGain >= 0)
      |=> accOut == MAX_P);  // R5

  AST_CLAMP_LOW: assert property (@(posedge sampleClk) disable iff (rst)
    (sampleValid && accOut == MIN_P && obsSum >= 0 && obsGain <= 0)
      |=> accOut == MIN_P);  // R6

endmodule

bind trap_integrator trap_integrator_chk #(
  .DATA_W      (DATA_W),
  .GAIN_W      (GAIN_W),
  .ACC_W       (ACC_W),
  .SIGNED_DATA (SIGNED_DATA)
) chk (
  .sampleClk   (sampleClk),
  .rst         (rst),
  .sampleValid (sampleValid),
  .errIn       (errIn),
  .gainIn      (gainIn),
  .accOut      (accOut)
);

// File: tb/trap_integrator_test.sv
module trap_integrator_test;

  localparam int DATA_W = 12;
  localparam int GAIN_W = 8;
  localparam int ACC_W  = 24;
  localparam longint ACC_MAX = 64'sd8388607;
  localparam longint ACC_MIN = -64'sd8388608;
  localparam int NV = 10;
  localparam int ROW_W = 1 + DATA_W + GAIN_W;

  // {valid, error, gain}
  localparam logic [ROW_W-1:0] TBL [NV] = '{
    {1'b1,  12'sd100,   8'sd3},
    {1'b1, -12'sd50,    8'sd3},
    {1'b0,  12'sd700,   8'sd5},
    {1'b1, -12'sd200,  -8'sd2},
    {1'b1,  12'sd7,     8'sd1},
    {1'b1, -12'sd2048,  8'sd127},
    {1'b1,  12'sd2047, -8'sd128},
    {1'b0,  12'sd0,     8'sd0},
    {1'b1,  12'sd0,     8'sd1},
    {1'b1, -12'sd1,     8'sd1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sampleValid = 1'b0;
  logic [DATA_W-1:0] errIn = '0;
  logic [GAIN_W-1:0] gainIn = '0;
  logic [ACC_W-1:0]  accOut;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;
  longint mPrev = 0;
  longint mAcc  = 0;

  always #2 clk = ~clk;

  trap_integrator uut (
    .clk         (clk),
    .rst         (rst),
    .sampleValid (sampleValid),
    .errIn       (errIn),
    .gainIn      (gainIn),
    .accOut      (accOut)
  );

  function automatic longint accVal();
    return longint'($signed(accOut));
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic drive(input logic v, input longint e, input longint g);
    longint s, p, h, n;
    sampleValid = v;
    errIn  = DATA_W'(e);
    gainIn = GAIN_W'(g);
    @(negedge clk);
    if (v) begin
      s = e + mPrev;
      p = s * g;
      h = p >>> 1;
      n = mAcc + h;
      if (n > ACC_MAX) n = ACC_MAX;
      if (n < ACC_MIN) n = ACC_MIN;
      mAcc  = n;
      mPrev = e;
    end
    sampleValid = 1'b0;
  endtask

  task automatic doReset(input logic v);
    rst = 1'b1;
    sampleValid = v;
    errIn = DATA_W'(500);
    gainIn = GAIN_W'(1);
    @(negedge clk);
    rst = 1'b0;
    sampleValid = 1'b0;
    mAcc = 0;
    mPrev = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    doReset(1'b0);
    check("R1 reset state", accVal(), 0);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      logic [ROW_W-1:0] row;
      longint e, g;
      row = TBL[i];
      e = longint'($signed(row[DATA_W+GAIN_W-1:GAIN_W]));
      g = longint'($signed(row[GAIN_W-1:0]));
      drive(row[ROW_W-1], e, g);
      check(row[ROW_W-1] ? "R2 table step" : "R4 table idle", accVal(), mAcc);
    end

    // R1: reset wins over a sample on the same edge
    drive(1'b1, 300, 4);
    doReset(1'b1);
    check("R1 reset with valid", accVal(), 0);
    drive(1'b1, 0, 1);
    check("R1 prev cleared", accVal(), 0);

    // R3 and R4: previous sample survives an idle edge
    doReset(1'b0);
    drive(1'b1, 10, 1);
    check("R3 first sample pairs with zero", accVal(), 5);
    drive(1'b0, 999, 7);
    check("R4 idle holds total", accVal(), 5);
    drive(1'b1, 0, 2);
    check("R3 prev kept through idle", accVal(), 15);

    // R7: no change before the active edge
    sampleValid = 1'b1;
    errIn = DATA_W'(4);
    gainIn = GAIN_W'(1);
    #1;
    check("R7 before active edge", accVal(), 15);
    @(negedge clk);
    sampleValid = 1'b0;
    check("R7 after active edge", accVal(), 17);

    // R8: floor on odd products
    doReset(1'b0);
    drive(1'b1, 3, 1);
    check("R8 positive odd", accVal(), 1);
    drive(1'b1, -6, 1);
    check("R8 negative odd", accVal(), -1);
    drive(1'b1, 0, 1);
    check("R8 negative halving", accVal(), -4);

    // R5: positive clamp
    doReset(1'b0);
    for (int k = 0; k < 40; k++) drive(1'b1, 2047, 127);
    check("R5 positive clamp", accVal(), ACC_MAX);
    drive(1'b1, 2047, 127);
    check("R5 stays clamped", accVal(), ACC_MAX);

    // R6: reversal from the high limit to the low limit
    drive(1'b1, 2047, -128);
    check("R6 leaves high limit", accVal(), ACC_MAX - 262016);
    for (int k = 0; k < 80; k++) drive(1'b1, 2047, -128);
    check("R6 negative clamp", accVal(), ACC_MIN);

    finish();
  end

endmodule